// File: doc/BRIEF.md
# Watermark-Paced Burst Refill for a Serial Transmit Queue

This block models the transmit side of a serial port whose queue is refilled by a single DMA destination channel. A small FIFO drains at a fixed serial rate. Whenever its fill level has fallen to a programmable low-water mark, the channel raises a burst request and then writes a fixed number of words taken from the source. This repeats until a programmed number of words, the block, has been moved. Once the last word has been written, the block pulses a completion flag. The queue then drains, and the block goes quiet.

Software picks three values: the low-water mark, the burst length and the block length. It then pulses `start`. The burst length is meant to equal the queue depth minus the mark. At that setting a burst lands exactly in the room that existed when the request was raised, so the queue can reach completely full but never spills. A larger burst is accepted, but it is reported as a configuration error, and any word that arrives at a full queue is dropped and flagged. A read slot that finds the queue empty while words are still owed raises an underflow flag.

Top module: `wmdma_tx_path`

## Requirements
- R1: While reset is high, and afterwards until `start` is accepted, `dma_req`, `src_take`, `pop_valid`, `block_done`, `cfg_err`, `ovf_err` and `unf_err` are all 0.
- R2: While a block is in progress, a request (`dma_req` high for exactly one cycle) is raised whenever the fill level is at or below the latched watermark. A new request is considered only after the previous burst has finished, so a block of W words with burst length B produces ceil(W/B) requests.
- R3: The cycle after each request, the channel takes `src_data` on consecutive cycles (`src_take` high). The number of words taken is the burst length, or the remaining count if that is smaller. A block takes exactly W words in total.
- R4: Words leave on `pop_data`, qualified by `pop_valid`, in the same order in which they were taken.
- R5: The first pop comes PERIOD cycles after the first write of a block (`pop_valid` one cycle later), and later pops come every PERIOD cycles. Pops stop once every word has been written and the FIFO is empty, so no underflow is flagged at the end of a block.
- R6: `block_done` is high for exactly one cycle, in the cycle after the last word of the block is taken.
- R7: A word written while the FIFO holds DEPTH entries is dropped, and `ovf_err` is set. It stays set until the next accepted `start`.
- R8: A pop slot that finds the FIFO empty while words of the block are still unwritten sets `unf_err`. It stays set until the next accepted `start`.
- R9: One cycle after an accepted `start`, `cfg_err` is 1 if burst length plus watermark exceeds DEPTH, if the burst length is 0, or if the block length is 0. Otherwise it is 0. A zero burst or zero block moves no words and produces no `block_done`.
- R10: A `start` that arrives while a block is writing or draining is ignored. Configuration inputs that change mid-block have no effect.
- R11: With the burst length set to DEPTH minus watermark and a watermark of at least 1, no overflow and no underflow occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a block (taken only when idle) |
| cfg_watermark | input | LW | Low-water fill level that triggers a request |
| cfg_burst_len | input | LW | Words per burst |
| cfg_block_words | input | BSW | Words in the block |
| src_data | input | DW | Source word, captured when `src_take` is high |
| src_take | output | 1 | Channel writes `src_data` into the FIFO this cycle |
| dma_req | output | 1 | Burst request, one cycle per burst |
| pop_valid | output | 1 | Serial side received a word this cycle |
| pop_data | output | DW | Word handed to the serial side |
| block_done | output | 1 | One-cycle pulse after the last write of a block |
| cfg_err | output | 1 | Configuration rule broken at the last accepted start |
| ovf_err | output | 1 | A word was dropped on a full FIFO |
| unf_err | output | 1 | A pop slot found the FIFO empty with words still owed |

## Verification
Every result has a fixed delay. `cfg_err` settles one cycle after the edge that accepts `start`. `dma_req` rises one cycle after the edge at which the level reaches the watermark, and `src_take` follows in the next cycle. `block_done` appears in the cycle after the last `src_take`. The first `pop_valid` is seen PERIOD+1 cycles after the first `src_take`, and each later one PERIOD cycles after the one before. The bench drives inputs and samples outputs on the falling edge, so each check reads these registers exactly in the cycle they are due. Totals such as request count, take count, pop count and the sticky flags are checked only after a drain window long enough to empty a full FIFO. Across a sweep of watermarks, burst lengths and block lengths, the expected values are ceil(W/B) requests, W takes and W pops in source order.

// File: rtl/wmdma_pkg.sv
package wmdma_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DRAIN} phase_t;
  typedef enum logic [1:0] {BS_WAIT, BS_REQ, BS_MOVE} bstate_t;
endpackage

// File: rtl/wmdma_fifo.sv
module wmdma_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] level,
  output logic          wr_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, wr_ok, rd_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign wr_drop = wr_en && full;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
      unique case ({wr_ok, rd_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/wmdma_ctrl.sv
module wmdma_ctrl
  import wmdma_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BSW   = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [LW-1:0]  cfg_wm,
  input  logic [LW-1:0]  cfg_burst,
  input  logic [BSW-1:0] cfg_block,
  input  logic [LW-1:0]  level,
  output logic           launch,
  output logic           src_take,
  output logic           dma_req,
  output logic           block_done,
  output logic           cfg_err,
  output logic           active,
  output logic           all_written
);
  phase_t         phase;
  bstate_t        bst;
  logic [LW-1:0]  wm_q, burst_q, beats;
  logic [BSW-1:0] left;
  logic [LW:0]    need;
  logic           fatal_cfg, bad_cfg;

  assign need      = {1'b0, cfg_burst} + {1'b0, cfg_wm};
  assign fatal_cfg = (cfg_burst == '0) || (cfg_block == '0);
  assign bad_cfg   = fatal_cfg || (need > (LW+1)'(DEPTH));
  assign launch    = (phase == PH_IDLE) && start;

  assign dma_req     = (phase == PH_RUN) && (bst == BS_REQ);
  assign src_take    = (phase == PH_RUN) && (bst == BS_MOVE);
  assign active      = (phase != PH_IDLE);
  assign all_written = (phase == PH_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      bst        <= BS_WAIT;
      wm_q       <= '0;
      burst_q    <= '0;
      beats      <= '0;
      left       <= '0;
      block_done <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      block_done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            cfg_err <= bad_cfg;
            if (!fatal_cfg) begin
              phase   <= PH_RUN;
              bst     <= BS_WAIT;
              wm_q    <= cfg_wm;
              burst_q <= cfg_burst;
              left    <= cfg_block;
            end
          end
        end
        PH_RUN: begin
          unique case (bst)
            BS_WAIT: begin
              if (level <= wm_q) begin
                bst   <= BS_REQ;
                beats <= (left < BSW'(burst_q)) ? LW'(left) : burst_q;
              end
            end
            BS_REQ: bst <= BS_MOVE;
            BS_MOVE: begin
              left  <= left - BSW'(1);
              beats <= beats - LW'(1);
              if (beats == LW'(1)) bst <= BS_WAIT;
              if (left == BSW'(1)) begin
                phase      <= PH_DRAIN;
                bst        <= BS_WAIT;
                block_done <= 1'b1;
              end
            end
            default: bst <= BS_WAIT;
          endcase
        end
        PH_DRAIN: begin
          if (level == '0) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wmdma_drain.sv
module wmdma_drain #(
  parameter int PERIOD = 3,
  localparam int CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic wr_fire,
  input  logic empty,
  input  logic all_written,
  output logic pop_en,
  output logic starve
);
  logic armed, tick;

  always_ff @(posedge clk) begin
    if (rst || !active) armed <= 1'b0;
    else if (wr_fire)   armed <= 1'b1;
  end

  generate
    if (PERIOD == 1) begin : g_every
      assign tick = armed;
    end else begin : g_paced
      logic [CW-1:0] tcnt;
      always_ff @(posedge clk) begin
        if (rst || !armed) tcnt <= '0;
        else if (tcnt == CW'(PERIOD - 1)) tcnt <= '0;
        else tcnt <= tcnt + CW'(1);
      end
      assign tick = armed && (tcnt == CW'(PERIOD - 1));
    end
  endgenerate

  assign pop_en = tick && !empty;
  assign starve = tick && empty && !all_written;
endmodule

// File: rtl/wmdma_tx_path.sv
module wmdma_tx_path #(
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  parameter int BSW    = 8,
  parameter int PERIOD = 3,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [LW-1:0]  cfg_watermark,
  input  logic [LW-1:0]  cfg_burst_len,
  input  logic [BSW-1:0] cfg_block_words,
  input  logic [DW-1:0]  src_data,
  output logic           src_take,
  output logic           dma_req,
  output logic           pop_valid,
  output logic [DW-1:0]  pop_data,
  output logic           block_done,
  output logic           cfg_err,
  output logic           ovf_err,
  output logic           unf_err
);
  logic [LW-1:0] fifo_level;
  logic launch, active, all_written, pop_en, starve, wr_drop;

  wmdma_ctrl #(.DEPTH(DEPTH), .BSW(BSW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .cfg_wm(cfg_watermark), .cfg_burst(cfg_burst_len), .cfg_block(cfg_block_words),
    .level(fifo_level), .launch(launch), .src_take(src_take), .dma_req(dma_req),
    .block_done(block_done), .cfg_err(cfg_err), .active(active), .all_written(all_written)
  );

  wmdma_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(src_take), .wr_data(src_data),
    .rd_en(pop_en), .rd_data(pop_data), .rd_valid(pop_valid),
    .level(fifo_level), .wr_drop(wr_drop)
  );

  wmdma_drain #(.PERIOD(PERIOD)) u_drain (
    .clk(clk), .rst(rst), .active(active), .wr_fire(src_take),
    .empty(fifo_level == '0), .all_written(all_written),
    .pop_en(pop_en), .starve(starve)
  );

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (wr_drop) ovf_err <= 1'b1;
      if (starve)  unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/wmdma_tx_path_chk.sv
module wmdma_tx_path_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_req,
  input logic          src_take,
  input logic          block_done,
  input logic          pop_valid,
  input logic          ovf_err,
  input logic          unf_err,
  input logic          launch,
  input logic [LW-1:0] level
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) dma_req |=> !dma_req); // R2
  AST_REQ_THEN_TAKE: assert property (@(posedge clk) disable iff (rst) dma_req |=> src_take); // R3
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst) pop_valid |-> $past(level) != '0); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) block_done |=> !block_done); // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) block_done |-> $past(src_take)); // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) level <= LW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) $fell(ovf_err) |-> $past(launch)); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst) $fell(unf_err) |-> $past(launch)); // R8
endmodule

bind wmdma_tx_path wmdma_tx_path_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .dma_req(dma_req), .src_take(src_take),
  .block_done(block_done), .pop_valid(pop_valid), .ovf_err(ovf_err),
  .unf_err(unf_err), .launch(launch), .level(fifo_level)
);

// File: tb/wmdma_tx_path_tb.sv
module wmdma_tx_path_tb;
  localparam int DEPTH = 8, DW = 8, BSW = 8, PERIOD = 3;
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LW-1:0] cfg_watermark = '0, cfg_burst_len = '0;
  logic [BSW-1:0] cfg_block_words = '0;
  logic [DW-1:0] src_data;
  logic src_take, dma_req, pop_valid, block_done, cfg_err, ovf_err, unf_err;
  logic [DW-1:0] pop_data;

  always #2 clk = ~clk;

  wmdma_tx_path #(.DEPTH(DEPTH), .DW(DW), .BSW(BSW), .PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_watermark(cfg_watermark),
    .cfg_burst_len(cfg_burst_len), .cfg_block_words(cfg_block_words),
    .src_data(src_data), .src_take(src_take), .dma_req(dma_req),
    .pop_valid(pop_valid), .pop_data(pop_data), .block_done(block_done),
    .cfg_err(cfg_err), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  function automatic logic [DW-1:0] word_at(input int i);
    return DW'(i * 7 + 3);
  endfunction

  int idx = 0;
  assign src_data = word_at(idx);
  always @(posedge clk) if (src_take) idx <= idx + 1;

  int checks = 0, fails = 0, cyc = 0;
  int takes, pops, reqs, dones, first_take, last_pop, base, cur_blk;
  bit chk_gap, chk_data, prev_req, prev_take;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      chk(1'b0, "watchdog", cyc, WDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (src_take) begin
      if (first_take < 0) first_take = cyc;
      takes++;
    end
    if (dma_req && !prev_req) reqs++;
    if (block_done) begin
      dones++;
      chk(prev_take && takes == cur_blk, "R6 done after last take", takes, cur_blk);
    end
    if (pop_valid) begin
      if (chk_data) chk(pop_data == word_at(base + pops), "R4 pop order", int'(pop_data), int'(word_at(base + pops)));
      if (chk_gap) begin
        if (pops == 0) chk(cyc - first_take == PERIOD + 1, "R5 first pop delay", cyc - first_take, PERIOD + 1);
        else chk(cyc - last_pop == PERIOD, "R5 pop spacing", cyc - last_pop, PERIOD);
      end
      last_pop = cyc;
      pops++;
    end
    prev_req = dma_req;
    prev_take = src_take;
  end

  // exp_unf / exp_ovf: 0 or 1 expected, 2 means not checked
  task automatic run(input int wm, input int b, input int blk, input bit exp_cfg,
                     input int exp_unf, input int exp_ovf, input bit inject);
    bit fatal;
    fatal = (b == 0) || (blk == 0);
    @(negedge clk);
    takes = 0; pops = 0; reqs = 0; dones = 0; first_take = -1; last_pop = 0;
    base = idx; cur_blk = blk;
    chk_data = (exp_ovf != 1);
    chk_gap = (exp_unf == 0);
    cfg_watermark = LW'(wm); cfg_burst_len = LW'(b); cfg_block_words = BSW'(blk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == exp_cfg, "R9 cfg_err", int'(cfg_err), int'(exp_cfg));
    for (int n = 0; n < 600 && dones == 0; n++) begin
      @(negedge clk);
      if (inject && n == 10) begin
        start = 1'b1; cfg_block_words = BSW'(3); cfg_watermark = '0;
      end else start = 1'b0;
    end
    start = 1'b0;
    repeat ((DEPTH + 3) * PERIOD + 8) @(negedge clk);
    if (fatal) begin
      chk(takes == 0 && dones == 0, "R9 no transfer", takes + dones, 0);
    end else begin
      chk(takes == blk, "R3 words taken", takes, blk);
      chk(reqs == (blk + b - 1) / b, "R2 request count", reqs, (blk + b - 1) / b);
      chk(dones == 1, "R6 done count", dones, 1);
      if (exp_ovf == 1) chk(pops < blk, "R7 dropped words", pops, blk);
      else chk(pops == blk, inject ? "R10 start ignored" : "R5 pop count", pops, blk);
      if (exp_ovf != 2) chk(ovf_err == exp_ovf[0], "R7 ovf_err", int'(ovf_err), exp_ovf);
      if (exp_unf != 2) chk(unf_err == exp_unf[0], "R8 unf_err", int'(unf_err), exp_unf);
      if (exp_ovf == 0 && exp_unf == 0 && b + wm == DEPTH)
        chk(!ovf_err && !unf_err, "R11 sized burst clean", int'(ovf_err) + int'(unf_err), 0);
    end
  endtask

  initial begin
    takes = 0; pops = 0; reqs = 0; dones = 0; first_take = -1; last_pop = 0;
    base = 0; cur_blk = 0; chk_gap = 0; chk_data = 0; prev_req = 0; prev_take = 0;
    repeat (3) @(negedge clk);
    chk({dma_req, src_take, pop_valid, block_done, cfg_err, ovf_err, unf_err} == '0,
        "R1 outputs in reset", 1, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk({dma_req, src_take, pop_valid, block_done, cfg_err, ovf_err, unf_err} == '0,
        "R1 outputs idle", 1, 0);

    // sweep of sized bursts over several block lengths (R2 R3 R4 R5 R6 R11)
    for (int wm = 1; wm <= DEPTH - 2; wm++) begin
      run(wm, DEPTH - wm, 1, 1'b0, 0, 0, 1'b0);
      run(wm, DEPTH - wm, DEPTH - wm + 1, 1'b0, 0, 0, 1'b0);
      run(wm, DEPTH - wm, 30, 1'b0, 0, 0, 1'b0);
    end
    run(7, 1, 9, 1'b0, 0, 0, 1'b0);
    run(2, 3, 10, 1'b0, 0, 0, 1'b0);
    // underflow: empty-triggered single-word bursts (R8)
    run(0, 1, 6, 1'b0, 1, 0, 1'b0);
    // oversized burst: config error and overflow (R7 R9)
    run(6, 8, 16, 1'b1, 2, 1, 1'b0);
    // flags clear on the next accepted start (R7 R8)
    run(6, 2, 30, 1'b0, 0, 0, 1'b0);
    // fatal configurations (R9)
    run(6, 2, 0, 1'b1, 2, 2, 1'b0);
    run(6, 0, 5, 1'b1, 2, 2, 1'b0);
    // start during a block is ignored (R10)
    run(4, 4, 12, 1'b0, 0, 0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule